// File: doc/BRIEF.md
# Serial audio clock generator and rate detector

This block produces the framing clocks of a serial audio port and decides which sampling-speed class is in force. Every register runs on one reference clock. In master mode the reference clock serves as the audio master clock, and a frame counter divides it into a bit clock and a word clock. In slave mode the block makes no clocks. It oversamples the incoming master clock and word clock, counts master-clock periods in each word period, and from that count decides between normal-rate and quad-rate operation.

The speed class takes one of three values: normal, double or quad. The class is registered, and every change of class raises a one-cycle pulse that a recovery sequencer can use to restart downstream processing. Double speed can come from a pin or from a register bit, and it overrides every other source. Quad speed comes from a register bit in master mode and from the measured clock ratio in slave mode. A frame strobe marks the start of each word period in both modes.

Top module: `audio_clk_gen`

## Requirements
- R1: Master mode at normal or double speed: bclk_out has a period of 4 reference cycles at 50% duty, and wclk_out has a period of 256 reference cycles (64 bit-clock periods), high in the first half.
- R2: Master mode with quad_reg=1 and no double request: speed_mode is QUAD, bclk_out has a period of 2 reference cycles at 50% duty, and wclk_out has a period of 128 reference cycles (64 bit-clock periods).
- R3: When dbl_pin or dbl_reg is 1, speed_mode is DOUBLE in both modes. This overrides quad_reg and the ratio detection.
- R4: speed_mode encodes NORMAL=0, DOUBLE=1 and QUAD=2. It is registered and follows the control inputs one clock edge later. In master mode it is QUAD exactly when quad_reg=1 and double is not requested.
- R5: In slave mode, a measured count of 126 to 130 master-clock rising edges per word-clock period sets the quad decision, so speed_mode is QUAD when double is not requested.
- R6: In slave mode, a measured count of 254 to 258 clears the quad decision, so speed_mode is NORMAL when double is not requested.
- R7: In slave mode, ratio_err is set by any other measured count, or by the running count passing 258 with no word-clock edge. While ratio_err is set the previous quad decision is held. The next in-range count clears ratio_err.
- R8: rate_chg is 1 for exactly the cycles in which speed_mode takes a new value. In master mode the clocks are low for that cycle, and on the next cycle the divider restarts at frame start (wclk_out high, frame_stb 1).
- R9: frame_stb pulses once per word period. In master mode it coincides with each rise of wclk_out. In slave mode it pulses once for each rise of the incoming word clock.
- R10: In slave mode bclk_out and wclk_out are held low. In master mode ratio_err is 0 and the detector is cleared.
- R11: While rst_n is low: speed_mode is NORMAL, and bclk_out, wclk_out, frame_stb, rate_chg and ratio_err are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; in master mode it is also the audio master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = generate clocks (master), 0 = receive and measure (slave) |
| dbl_pin | input | 1 | Double-speed request from a pin, synchronous to clk |
| dbl_reg | input | 1 | Double-speed request from a control register bit |
| quad_reg | input | 1 | Quad-speed control register bit (master mode only) |
| mclk_in | input | 1 | Incoming master clock, oversampled by clk |
| wclk_in | input | 1 | Incoming word clock, oversampled by clk |
| bclk_out | output | 1 | Generated bit clock |
| wclk_out | output | 1 | Generated word clock |
| frame_stb | output | 1 | One-cycle strobe at the start of each word period |
| speed_mode | output | 2 | Speed class in force: 0 normal, 1 double, 2 quad |
| rate_chg | output | 1 | One-cycle pulse when speed_mode changes |
| ratio_err | output | 1 | Incoming master/word clock ratio out of tolerance |

## Verification
The assertions check on every cycle that each pulse of rate_chg matches a change of speed_mode, that the speed class follows the double request and the master-mode quad bit with the required priority, that the generated clocks stay low in slave mode, that the ratio flag stays clear in master mode, and that every rise of the generated word clock carries the frame strobe. Only the bench scenarios can show the actual divider periods and duty cycles, the tolerance edges of the ratio windows (125/126, 130/131, 253/254, 258/259), the hold of the quad decision while ratio_err is set, the error raised by a stopped word clock, and the restart of the frame after a change of speed class.

// File: rtl/audio_clk_pkg.sv
package audio_clk_pkg;

   typedef enum logic [1:0] {
      SPD_NORMAL = 2'd0,
      SPD_DOUBLE = 2'd1,
      SPD_QUAD   = 2'd2
   } speed_e;

endpackage

// File: rtl/acg_edge_sync.sv
// Oversamples an asynchronous clock-like input and flags its rising edges.
module acg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   logic level;
   logic prev;

   generate
      if (STAGES == 1) begin : g_single
         logic s0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s0 <= 1'b0;
            else        s0 <= din;
         end
         assign level = s0;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], din};
         end
         assign level = sh[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= level;
   end

   assign rise = level & ~prev;

endmodule

// File: rtl/acg_ratio_meter.sv
// Counts master-clock edges per word-clock period and classifies the ratio.
module acg_ratio_meter #(
   parameter int RATIO_NORM = 256,
   parameter int RATIO_QUAD = 128,
   parameter int TOL        = 2,
   parameter int CNT_W      = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic mclk_rise,
   input  logic wclk_rise,
   output logic quad_det,
   output logic ratio_err
);

   localparam logic [CNT_W-1:0] NORM_LO = CNT_W'(RATIO_NORM - TOL);
   localparam logic [CNT_W-1:0] NORM_HI = CNT_W'(RATIO_NORM + TOL);
   localparam logic [CNT_W-1:0] QUAD_LO = CNT_W'(RATIO_QUAD - TOL);
   localparam logic [CNT_W-1:0] QUAD_HI = CNT_W'(RATIO_QUAD + TOL);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt;
   logic             armed;
   logic             in_norm;
   logic             in_quad;

   assign in_norm = (cnt >= NORM_LO) && (cnt <= NORM_HI);
   assign in_quad = (cnt >= QUAD_LO) && (cnt <= QUAD_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         armed     <= 1'b0;
         quad_det  <= 1'b0;
         ratio_err <= 1'b0;
      end else if (clr) begin
         cnt       <= '0;
         armed     <= 1'b0;
         quad_det  <= 1'b0;
         ratio_err <= 1'b0;
      end else if (wclk_rise) begin
         cnt   <= mclk_rise ? CNT_W'(1) : '0;
         armed <= 1'b1;
         if (armed) begin
            if (in_norm) begin
               quad_det  <= 1'b0;
               ratio_err <= 1'b0;
            end else if (in_quad) begin
               quad_det  <= 1'b1;
               ratio_err <= 1'b0;
            end else begin
               ratio_err <= 1'b1;
            end
         end
      end else begin
         if (mclk_rise && (cnt != CNT_MAX)) cnt <= cnt + 1'b1;
         if (cnt > NORM_HI) ratio_err <= 1'b1;
      end
   end

endmodule

// File: rtl/acg_divider.sv
// Frame counter tapped for bit clock and word clock in master mode.
module acg_divider #(
   parameter int RATIO_NORM    = 256,
   parameter int RATIO_QUAD    = 128,
   parameter int BCLK_PER_WORD = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic quad,
   output logic bclk,
   output logic wclk,
   output logic stb
);

   localparam int CW    = $clog2(RATIO_NORM);
   localparam int BIT_N = $clog2(RATIO_NORM / BCLK_PER_WORD) - 1;
   localparam int BIT_Q = $clog2(RATIO_QUAD / BCLK_PER_WORD) - 1;
   localparam int MSB_N = CW - 1;
   localparam int MSB_Q = $clog2(RATIO_QUAD) - 1;
   localparam logic [CW-1:0] LAST_N = CW'(RATIO_NORM - 1);
   localparam logic [CW-1:0] LAST_Q = CW'(RATIO_QUAD - 1);

   logic [CW-1:0] cnt;
   logic          en_q;
   logic          live;
   logic          btap;
   logic          wtap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         cnt  <= '0;
      end else begin
         en_q <= run;
         if (!en_q || restart)
            cnt <= '0;
         else if (cnt >= (quad ? LAST_Q : LAST_N))
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end
   end

   assign live = en_q & ~restart;
   assign btap = quad ? cnt[BIT_Q] : cnt[BIT_N];
   assign wtap = quad ? cnt[MSB_Q] : cnt[MSB_N];
   assign bclk = live & btap;
   assign wclk = live & ~wtap;
   assign stb  = live & (cnt == '0);

endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
   import audio_clk_pkg::*;
#(
   parameter int RATIO_NORM    = 256,
   parameter int RATIO_QUAD    = 128,
   parameter int BCLK_PER_WORD = 64,
   parameter int RATIO_TOL     = 2,
   parameter int SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       master_en,
   input  logic       dbl_pin,
   input  logic       dbl_reg,
   input  logic       quad_reg,
   input  logic       mclk_in,
   input  logic       wclk_in,
   output logic       bclk_out,
   output logic       wclk_out,
   output logic       frame_stb,
   output logic [1:0] speed_mode,
   output logic       rate_chg,
   output logic       ratio_err
);

   localparam int CNT_W = $clog2(RATIO_NORM + RATIO_TOL + 2);

   // Elaboration-time parameter checks
   generate
      if ((RATIO_NORM & (RATIO_NORM - 1)) != 0) begin : g_bad_norm
         $error("RATIO_NORM must be a power of two");
      end
      if (RATIO_QUAD * 2 != RATIO_NORM) begin : g_bad_quad
         $error("RATIO_QUAD must be half of RATIO_NORM");
      end
      if ((BCLK_PER_WORD & (BCLK_PER_WORD - 1)) != 0) begin : g_bad_bpw
         $error("BCLK_PER_WORD must be a power of two (48 is rejected)");
      end
      if (RATIO_QUAD / BCLK_PER_WORD < 2) begin : g_bad_div
         $error("quad ratio leaves no room for a 50 percent bit clock");
      end
      if (RATIO_TOL * 4 >= RATIO_QUAD) begin : g_bad_tol
         $error("RATIO_TOL too wide for the quad window");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic   mclk_rise;
   logic   wclk_rise;
   logic   quad_det;
   logic   div_stb;
   logic   div_bclk;
   logic   div_wclk;
   logic   dbl_any;
   logic   quad_sel;
   speed_e speed_q;
   speed_e speed_nx;
   logic   chg_q;

   acg_edge_sync #(.STAGES(SYNC_STAGES)) u_mclk_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (mclk_in),
      .rise  (mclk_rise)
   );

   acg_edge_sync #(.STAGES(SYNC_STAGES)) u_wclk_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (wclk_in),
      .rise  (wclk_rise)
   );

   acg_ratio_meter #(
      .RATIO_NORM (RATIO_NORM),
      .RATIO_QUAD (RATIO_QUAD),
      .TOL        (RATIO_TOL),
      .CNT_W      (CNT_W)
   ) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (master_en),
      .mclk_rise (mclk_rise),
      .wclk_rise (wclk_rise),
      .quad_det  (quad_det),
      .ratio_err (ratio_err)
   );

   // Speed class: double overrides, then quad source depends on mode
   assign dbl_any  = dbl_pin | dbl_reg;
   assign quad_sel = master_en ? quad_reg : quad_det;

   always_comb begin
      if (dbl_any)       speed_nx = SPD_DOUBLE;
      else if (quad_sel) speed_nx = SPD_QUAD;
      else               speed_nx = SPD_NORMAL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         speed_q <= SPD_NORMAL;
         chg_q   <= 1'b0;
      end else begin
         speed_q <= speed_nx;
         chg_q   <= (speed_nx != speed_q);
      end
   end

   acg_divider #(
      .RATIO_NORM    (RATIO_NORM),
      .RATIO_QUAD    (RATIO_QUAD),
      .BCLK_PER_WORD (BCLK_PER_WORD)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (master_en),
      .restart (chg_q),
      .quad    (speed_q == SPD_QUAD),
      .bclk    (div_bclk),
      .wclk    (div_wclk),
      .stb     (div_stb)
   );

   assign bclk_out   = div_bclk;
   assign wclk_out   = div_wclk;
   assign frame_stb  = master_en ? div_stb : wclk_rise;
   assign speed_mode = speed_q;
   assign rate_chg   = chg_q;

endmodule

// File: rtl/audio_clk_gen_chk.sv
module audio_clk_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       master_en,
   input logic       dbl_pin,
   input logic       dbl_reg,
   input logic       quad_reg,
   input logic       bclk_out,
   input logic       wclk_out,
   input logic       frame_stb,
   input logic [1:0] speed_mode,
   input logic       rate_chg,
   input logic       ratio_err
);

   logic pv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pv <= 1'b0;
      else        pv <= 1'b1;
   end

   assert_rate_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pv && (speed_mode != $past(speed_mode)) |-> rate_chg);

   assert_rate_only_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pv && rate_chg |-> (speed_mode != $past(speed_mode)));

   assert_double_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pv && $past(dbl_pin || dbl_reg) |-> (speed_mode == 2'd1));

   assert_master_quad_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pv && $past(master_en && !dbl_pin && !dbl_reg && quad_reg) |-> (speed_mode == 2'd2));

   assert_master_normal_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pv && $past(master_en && !dbl_pin && !dbl_reg && !quad_reg) |-> (speed_mode == 2'd0));

   assert_slave_clocks_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pv && !$past(master_en) |-> (!bclk_out && !wclk_out));

   assert_master_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pv && master_en && $past(master_en) |-> !ratio_err);

   assert_stb_on_word_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pv && master_en && $past(master_en) && $rose(wclk_out) |-> frame_stb);

endmodule

bind audio_clk_gen audio_clk_gen_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .master_en  (master_en),
   .dbl_pin    (dbl_pin),
   .dbl_reg    (dbl_reg),
   .quad_reg   (quad_reg),
   .bclk_out   (bclk_out),
   .wclk_out   (wclk_out),
   .frame_stb  (frame_stb),
   .speed_mode (speed_mode),
   .rate_chg   (rate_chg),
   .ratio_err  (ratio_err)
);

// File: tb/audio_clk_gen_tb.sv
`timescale 1ns/1ps
module audio_clk_gen_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       master_en = 1'b1;
   logic       dbl_pin = 1'b0;
   logic       dbl_reg = 1'b0;
   logic       quad_reg = 1'b0;
   logic       mclk_in = 1'b0;
   logic       wclk_in = 1'b0;
   logic       bclk_out;
   logic       wclk_out;
   logic       frame_stb;
   logic [1:0] speed_mode;
   logic       rate_chg;
   logic       ratio_err;

   int n_chk  = 0;
   int n_fail = 0;
   int n_rc   = 0;

   always #2.5 clk = ~clk;

   audio_clk_gen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .master_en  (master_en),
      .dbl_pin    (dbl_pin),
      .dbl_reg    (dbl_reg),
      .quad_reg   (quad_reg),
      .mclk_in    (mclk_in),
      .wclk_in    (wclk_in),
      .bclk_out   (bclk_out),
      .wclk_out   (wclk_out),
      .frame_stb  (frame_stb),
      .speed_mode (speed_mode),
      .rate_chg   (rate_chg),
      .ratio_err  (ratio_err)
   );

   // Incoming clock generator: mclk period 2 cycles, wclk period gen_ratio mclk periods
   int gen_ratio = 256;
   bit gen_hold  = 1'b0;
   int gcnt      = 0;

   always @(negedge clk) begin
      if (rate_chg) n_rc++;
      if (!mclk_in && !gen_hold) begin
         gcnt++;
         if (gcnt >= (wclk_in ? gen_ratio / 2 : gen_ratio - gen_ratio / 2)) begin
            wclk_in <= ~wclk_in;
            gcnt = 0;
         end
      end
      mclk_in <= ~mclk_in;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic apply(input bit m, input bit dp, input bit dr, input bit q, input int r);
      @(negedge clk);
      master_en = m;
      dbl_pin   = dp;
      dbl_reg   = dr;
      quad_reg  = q;
      gen_ratio = r;
   endtask

   // Measure one generated word period starting at a wclk_out rise
   task automatic meas(output int wper, output int nb, output int bhi, output int nstb);
      int  g;
      bit  found;
      logic pw, pb;
      wper = 0; nb = 0; bhi = 0; nstb = 0; g = 0; found = 0;
      @(negedge clk);
      pw = wclk_out;
      while (!found && g < 2000) begin
         @(negedge clk);
         g++;
         found = !pw && wclk_out;
         pw = wclk_out;
      end
      pb   = bclk_out;
      bhi  = int'(bclk_out);
      nstb = int'(frame_stb);
      wper = 1;
      found = 0;
      while (!found && g < 4000) begin
         @(negedge clk);
         g++;
         if (!pw && wclk_out) found = 1;
         else begin
            wper++;
            bhi += int'(bclk_out);
            if (!pb && bclk_out) nb++;
            nstb += int'(frame_stb);
         end
         pw = wclk_out;
         pb = bclk_out;
      end
   endtask

   // master, dbl_pin, dbl_reg, quad_reg, ratio, expected mode, expected err
   localparam int NV = 14;
   localparam int TV [NV][7] = '{
      '{1, 0, 0, 0, 256, 0, 0},
      '{1, 0, 0, 1, 256, 2, 0},
      '{1, 1, 0, 1, 256, 1, 0},
      '{1, 0, 1, 0, 256, 1, 0},
      '{0, 0, 0, 0, 256, 0, 0},
      '{0, 0, 0, 0, 128, 2, 0},
      '{0, 0, 0, 0, 130, 2, 0},
      '{0, 0, 0, 0, 126, 2, 0},
      '{0, 0, 0, 0, 131, 2, 1},
      '{0, 0, 0, 0, 258, 0, 0},
      '{0, 0, 0, 0, 254, 0, 0},
      '{0, 0, 0, 0, 253, 0, 1},
      '{0, 1, 0, 0, 128, 1, 0},
      '{0, 0, 0, 0, 259, 2, 1}
   };

   function automatic string req_of(input int i);
      case (i)
         0:          return "R1";
         1:          return "R2";
         2, 3, 12:   return "R3";
         5, 6, 7:    return "R5";
         4, 9, 10:   return "R6";
         default:    return "R7";
      endcase
   endfunction

   initial begin
      int wper, nb, bhi, nstb, rc0, nrise;
      bit hi;
      logic pwi;

      // Reset state
      repeat (4) @(negedge clk);
      chk(speed_mode == 2'd0, "R11 speed_mode", speed_mode, 0);
      chk(!bclk_out && !wclk_out, "R11 clocks", {bclk_out, wclk_out}, 0);
      chk(!frame_stb && !rate_chg && !ratio_err, "R11 flags",
          {frame_stb, rate_chg, ratio_err}, 0);
      rst_n = 1'b1;
      repeat (8) @(negedge clk);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         apply(TV[i][0] != 0, TV[i][1] != 0, TV[i][2] != 0, TV[i][3] != 0, TV[i][4]);
         hi = 0;
         repeat (12 * TV[i][4] + 64) begin
            @(negedge clk);
            if (bclk_out || wclk_out) hi = 1;
         end
         chk(speed_mode == 2'(TV[i][5]), {req_of(i), " R4 mode"}, speed_mode, TV[i][5]);
         chk(ratio_err == TV[i][6][0], {req_of(i), " ratio_err"}, ratio_err, TV[i][6]);
         if (TV[i][0] != 0) begin
            meas(wper, nb, bhi, nstb);
            chk(wper == (TV[i][5] == 2 ? 128 : 256), {req_of(i), " word period"}, wper,
                TV[i][5] == 2 ? 128 : 256);
            chk(nb == 64, {req_of(i), " bit clocks per word"}, nb, 64);
            chk(bhi * 2 == wper, {req_of(i), " bit clock duty"}, bhi * 2, wper);
            chk(nstb == 1, "R9 master strobe per word", nstb, 1);
         end else begin
            chk(!hi, "R10 slave clocks low", int'(hi), 0);
         end
      end

      // Rate change pulse and divider restart
      apply(1, 0, 0, 0, 256);
      repeat (600) @(negedge clk);
      rc0 = n_rc;
      quad_reg = 1'b1;
      @(negedge clk);
      chk(speed_mode == 2'd2 && rate_chg, "R8 pulse with new mode", {speed_mode, rate_chg}, 5);
      chk(!wclk_out && !bclk_out, "R8 clocks low during change", {bclk_out, wclk_out}, 0);
      @(negedge clk);
      chk(!rate_chg, "R8 pulse one cycle", rate_chg, 0);
      chk(wclk_out && frame_stb, "R8 restart at frame start", {wclk_out, frame_stb}, 3);
      repeat (300) @(negedge clk);
      chk(n_rc - rc0 == 1, "R8 single pulse", n_rc - rc0, 1);
      meas(wper, nb, bhi, nstb);
      chk(wper == 128, "R2 word period after change", wper, 128);

      // Slave strobe per incoming word period
      apply(0, 0, 0, 0, 256);
      repeat (3200) @(negedge clk);
      nstb = 0; nrise = 0; pwi = wclk_in;
      repeat (2048) begin
         @(negedge clk);
         nstb += int'(frame_stb);
         if (!pwi && wclk_in) nrise++;
         pwi = wclk_in;
      end
      chk(nstb >= 3 && (nstb - nrise <= 1) && (nrise - nstb <= 1),
          "R9 slave strobe count", nstb, nrise);

      // Stopped word clock raises the ratio error, quad decision held
      chk(!ratio_err && speed_mode == 2'd0, "R6 settled normal", {speed_mode, ratio_err}, 0);
      gen_hold = 1'b1;
      repeat (700) @(negedge clk);
      chk(ratio_err, "R7 stopped word clock", ratio_err, 1);
      chk(speed_mode == 2'd0, "R7 mode held", speed_mode, 0);
      gen_hold = 1'b0;
      repeat (3200) @(negedge clk);
      chk(!ratio_err, "R7 error cleared", ratio_err, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule